// File: doc/BRIEF.md
# Serially Programmed Twelve-Channel Trim Code Bank

This block is the digital front end of a twelve-channel trim converter. A host writes it through a three-wire serial port with an active-low select, a serial clock and a data line. Each frame carries a channel address and an 8-bit code. When the select line returns high, the block decodes the address and updates one of twelve holding registers. Each holding register drives the code bus of one analog output channel.

Two further controls act on the whole bank. A preset input forces every channel to the mid-scale code at once. A shutdown input raises a power-down flag for the analog section and leaves every stored code as it was. The serial lines are synchronized into the system clock domain, and the block detects their edges there. For this reason the serial clock must run well below the system clock, with each level held for at least three system clocks.

Top module: `trim_bank_top`

## Requirements
- R1: When the synchronous reset is released, every channel code reads 8'h80 and the power-down flag is 0.
- R2: A frame is the last 12 bits sampled on rising serial-clock edges while select is low. The first 4 bits are the address and the last 8 bits are the code, both MSB first. Address value a writes channel a+1, which appears on `chan_code[8a+7:8a]`.
- R3: A frame changes one channel only. Every other channel keeps its code.
- R4: Channels can be written one at a time in any order, and a later write to the same channel replaces the earlier code.
- R5: A frame with address 12, 13, 14 or 15 changes no channel.
- R6: A frame that closes after fewer than 12 serial-clock rises is discarded, and no channel changes.
- R7: A frame longer than 12 bits uses only the last 12 bits sent. A 16-clock frame whose first 4 bits are don't-care therefore writes as a 12-bit frame would.
- R8: While `preset_n` is low, every channel reads 8'h80. This holds from the moment the input falls, without waiting for a clock edge.
- R9: A frame that completes while `preset_n` is low leaves every channel at 8'h80.
- R10: Two system clocks after `shdn_n` falls, `pwrdn_flag` reads 1, and every channel code is unchanged. Two system clocks after `shdn_n` rises again, the flag reads 0 and the codes are the same as before.
- R11: Serial-clock rises while select is high are not counted toward a frame.
- R12: A channel write shows on the code bus four system clocks after the rising edge of select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idles low, data sampled on its rise |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data |
| preset_n | input | 1 | Asynchronous active-low mid-scale preset |
| shdn_n | input | 1 | Active-low shutdown request |
| chan_code | output | 96 | Twelve 8-bit channel codes, channel 1 in the low byte |
| pwrdn_flag | output | 1 | Power-down indication for the analog section |

## Verification
From the ports, the hardest cases are the frames whose length differs from twelve and the frames sent while the bank is held in preset. The bench therefore sends frames of variable bit count: 4, 12 and 16 bits. It also pulses the serial clock while select is high. It then checks that only the last twelve counted bits act, and only when at least twelve were counted. A frame is sent with `preset_n` held low, and the bank is then checked for all mid-scale codes after release. The reference model updates its expected codes in the exact cycle given by R12, so a timing slip of one clock shows up as a mismatch.

// File: rtl/trim_pkg.sv
// Package: shared sizes and constants for the twelve-channel trim code bank.
// Assumes every channel code has the same width and the address field comes first.
package trim_pkg;
    localparam int NUM_CH    = 12;
    localparam int CODE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int FRAME_W   = ADDR_W + CODE_W;
    localparam int BUS_W     = NUM_CH * CODE_W;
    localparam int SYNC_LEN  = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Mid-scale code: only the top bit set.
    localparam code_t MID_CODE = code_t'(1) << (CODE_W - 1);
endpackage

// File: rtl/trim_sync.sv
// Module: multi-bit flop chain synchronizer with two output taps.
// Assumes each bit is an independent slow level. The last two stages are exposed
// so edges can be detected on the synchronized copy.
module trim_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync,
    output logic [WIDTH-1:0] q_prev
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    // Stage 0 captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage retimes the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign q_sync = chain_q[LAST-1];
    assign q_prev = chain_q[LAST];
endmodule

// File: rtl/trim_frame_rx.sv
// Module: serial frame receiver.
// Shifts one bit in on every synchronized serial-clock rise while select is low,
// keeps only the newest FRAME_W bits, and on the rise of select issues a one-cycle
// write strobe with address and code if at least FRAME_W bits were counted.
module trim_frame_rx
    import trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_rise,
    input  logic  sel_low,
    input  logic  sel_rise,
    input  logic  din_bit,
    output logic  wr_vld,
    output addr_t wr_addr,
    output code_t wr_code
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               full;

    assign full = (cnt_q == CNT_FULL);

    // Shift register: newest bit enters at the LSB, older bits fall off the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                 shift_q <= '0;
        else if (sclk_rise && sel_low) shift_q <= {shift_q[FRAME_W-2:0], din_bit};
    end

    // Bit counter: saturates at a full frame and clears when the frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (sel_rise || !sel_low)     cnt_q <= '0;
        else if (sclk_rise && !full)       cnt_q <= cnt_q + 1'b1;
    end

    // Write strobe: one cycle after the select rise, only for complete frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_code <= '0;
        end else begin
            wr_vld  <= sel_rise && full;
            wr_addr <= shift_q[FRAME_W-1 -: ADDR_W];
            wr_code <= shift_q[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/trim_latch_bank.sv
// Module: twelve holding registers with address decode and mid-scale preset.
// Assumes the preset is asynchronous and dominant; addresses at or above NUM_CH
// select no register.
module trim_latch_bank
    import trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset_n,
    input  logic             wr_vld,
    input  addr_t            wr_addr,
    input  code_t            wr_code,
    output logic [BUS_W-1:0] codes
);
    logic [NUM_CH-1:0] sel;

    // Address decoder: one-hot select of the addressed channel.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            sel[k] = wr_vld && (wr_addr == ADDR_W'(k));
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
            code_t hold_q;
            // Channel register: preset wins, then reset, then a decoded write.
            always_ff @(posedge clk or negedge preset_n) begin
                if (!preset_n)   hold_q <= MID_CODE;
                else if (!rst_n) hold_q <= MID_CODE;
                else if (sel[k]) hold_q <= wr_code;
            end
            assign codes[k*CODE_W +: CODE_W] = hold_q;
        end
    endgenerate
endmodule

// File: rtl/trim_bank_top.sv
// Module: top of the twelve-channel trim code bank.
// Synchronizes the serial port and shutdown input, receives frames, and drives
// the channel code bus and power-down flag. Assumes the serial clock levels last
// at least three system clocks.
module trim_bank_top
    import trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_sel_n,
    input  logic             ser_din,
    input  logic             preset_n,
    input  logic             shdn_n,
    output logic [BUS_W-1:0] chan_code,
    output logic             pwrdn_flag
);
    // Bit positions inside the synchronizer vector.
    localparam int B_SCLK = 0;
    localparam int B_SEL  = 1;
    localparam int B_DIN  = 2;
    localparam int B_SHDN = 3;
    localparam logic [3:0] SYNC_RST = 4'b1010;

    logic [3:0] raw_in, s_now, s_old;
    logic       sclk_rise, sel_low, sel_rise;
    logic       wr_vld;
    addr_t      wr_addr;
    code_t      wr_code;

    assign raw_in = {shdn_n, ser_din, ser_sel_n, ser_clk};

    trim_sync #(.WIDTH(4), .STAGES(SYNC_LEN), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (s_now),
        .q_prev  (s_old)
    );

    // Edge and level decode of the synchronized serial lines.
    always_comb begin
        sclk_rise = s_now[B_SCLK] && !s_old[B_SCLK];
        sel_low   = !s_now[B_SEL];
        sel_rise  = s_now[B_SEL] && !s_old[B_SEL];
    end

    trim_frame_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sel_low   (sel_low),
        .sel_rise  (sel_rise),
        .din_bit   (s_now[B_DIN]),
        .wr_vld    (wr_vld),
        .wr_addr   (wr_addr),
        .wr_code   (wr_code)
    );

    trim_latch_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_n (preset_n),
        .wr_vld   (wr_vld),
        .wr_addr  (wr_addr),
        .wr_code  (wr_code),
        .codes    (chan_code)
    );

    assign pwrdn_flag = !s_now[B_SHDN];
endmodule

// File: rtl/trim_bank_chk.sv
// Module: property checker for the trim code bank, bound to the top.
module trim_bank_chk
    import trim_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             preset_n,
    input logic [BUS_W-1:0] chan_code,
    input logic             pwrdn_flag,
    input logic             wr_vld,
    input addr_t            wr_addr
);
    logic [BUS_W-1:0]  prev_q;
    logic              prev_ok = 1'b0;
    logic              seen_q  = 1'b0;
    logic [NUM_CH-1:0] chg;

    // History of the code bus and of reset for change detection.
    always_ff @(posedge clk) begin
        prev_q  <= chan_code;
        prev_ok <= rst_n;
        seen_q  <= 1'b1;
    end

    // Per-channel change flags.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++)
            chg[k] = chan_code[k*CODE_W +: CODE_W] != prev_q[k*CODE_W +: CODE_W];
    end

    AST_RESET_MID: assert property (@(posedge clk)
        seen_q && $past(!rst_n) && preset_n |-> (chan_code == {NUM_CH{MID_CODE}}) && !pwrdn_flag); // R1
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok && preset_n && $past(preset_n) |-> $countones(chg) <= 1); // R3
    AST_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok && preset_n && $past(preset_n) && (chg != '0) |->
            $past(wr_vld) && ($past(wr_addr) < ADDR_W'(NUM_CH))); // R5
    AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |-> chan_code == {NUM_CH{MID_CODE}}); // R8
    AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok && preset_n && $past(preset_n) && $rose(pwrdn_flag) |-> chg == '0); // R10
endmodule

bind trim_bank_top trim_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_n   (preset_n),
    .chan_code  (chan_code),
    .pwrdn_flag (pwrdn_flag),
    .wr_vld     (wr_vld),
    .wr_addr    (wr_addr)
);

// File: tb/trim_bank_top_tb_top.sv
module trim_bank_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 12;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic        preset_n = 1'b1, shdn_n = 1'b1;
    logic [95:0] chan_code;
    logic        pwrdn_flag;

    int          total = 0, bad = 0, cycles = 0;
    logic        cmp_en = 1'b0;
    string       cur_req = "R1";
    logic [7:0]  exp_code [NCH];
    logic        exp_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_bank_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .preset_n(preset_n), .shdn_n(shdn_n),
        .chan_code(chan_code), .pwrdn_flag(pwrdn_flag)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
        end
    endtask

    // Reference comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int k = 0; k < NCH; k++)
                check(cur_req, $sformatf("chan%0d", k + 1), 32'(chan_code[k*8 +: 8]), 32'(exp_code[k]));
            check(cur_req, "pwrdn_flag", 32'(pwrdn_flag), 32'(exp_flag));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // Sends nbits of val MSB first; model applies the write per R2, R5, R6, R7, R9, R12.
    task automatic send(input int nbits, input logic [31:0] val);
        ser_sel_n = 1'b0;
        tick(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = val[i];
            ser_clk = 1'b0;
            tick(HALF);
            ser_clk = 1'b1;
            tick(HALF);
        end
        ser_clk = 1'b0;
        tick(HALF);
        ser_sel_n = 1'b1;
        tick(4);  // R12: latch visible after the fourth clock
        if (nbits >= 12 && val[11:8] < 4'd12 && preset_n)
            exp_code[val[11:8]] = val[7:0];
        tick(2);
    endtask

    task automatic set_shdn(input logic v);
        shdn_n = v;
        tick(2);
        exp_flag = ~v;
        tick(1);
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) exp_code[k] = 8'h80;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        for (int k = 0; k < NCH; k++)
            check("R1", "reset code", 32'(chan_code[k*8 +: 8]), 32'h80);
        check("R1", "reset flag", 32'(pwrdn_flag), 32'h0);
        cmp_en = 1'b1;

        cur_req = "R2";  send(12, 32'h0A5);   // addr 0 -> channel 1
        cur_req = "R2";  send(12, 32'hB3C);   // addr 11 -> channel 12
        cur_req = "R3";  send(12, 32'h5E7);
        cur_req = "R4";  send(12, 32'h711); send(12, 32'h222); send(12, 32'h733);
        cur_req = "R5";  send(12, 32'hCFF); send(12, 32'hF00);
        cur_req = "R6";  send(4, 32'h3); send(11, 32'h3EE);
        cur_req = "R7";  send(16, 32'hA94C);  // top nibble ignored -> addr 9
        cur_req = "R11";
        ser_sel_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            ser_clk = 1'b1; tick(HALF); ser_clk = 1'b0; tick(HALF);
        end
        send(4, 32'h6);                       // only 4 counted bits: no write
        cur_req = "R12"; send(12, 32'h4C3);
        cur_req = "R10";
        set_shdn(1'b0);
        tick(10);
        set_shdn(1'b1);
        tick(4);
        cur_req = "R8";
        preset_n = 1'b0;
        for (int k = 0; k < NCH; k++) exp_code[k] = 8'h80;
        #1;
        check("R8", "async preset chan2", 32'(chan_code[15:8]), 32'h80);
        tick(3);
        cur_req = "R9";  send(12, 32'h1EE);
        preset_n = 1'b1;
        tick(4);
        cur_req = "R2";  send(12, 32'h866);
        tick(4);
        cmp_en = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule